// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Condition Flags

This block is an 8-bit arithmetic and logic unit built around an accumulator. The accumulator is always the first operand, and it receives the result of every operation that produces one. The second operand arrives on a data input, and a register file or an instruction's immediate byte drives it from outside. An operation code selects the function. A one-cycle strobe commits the new accumulator and the new condition flags on the next rising clock edge.

The unit offers several groups of operations:
- addition and subtraction, each with or without the incoming carry or borrow;
- bitwise AND, OR and XOR, plus a compare;
- four one-bit accumulator rotates;
- a decimal correction step for packed two-digit BCD;
- a load that places the operand in the accumulator.

Five condition flags sit in a flag byte: carry, zero, sign, even parity and the nibble carry. The flag byte and the accumulator are also presented together as a 16-bit status word. Instruction decoding and the register file are outside the block.

Top module: `acc_alu`

## Requirements
- R1: While reset is asserted, and until the first strobe after its release, the accumulator and the flag byte both read 0x00.
- R2: When strobe is low, the accumulator and the flags hold their values, whatever op and operand carry. A strobe with op code 14 or 15 also leaves both unchanged.
- R3: Add (op 0) and add-with-carry (op 1) write acc + operand (+ C for op 1) to the accumulator. C is set to the carry out of bit 7, and AC is set to the carry out of bit 3.
- R4: Subtract (op 2) and subtract-with-borrow (op 3) write acc − operand (− C for op 3) to the accumulator. C is set to 1 when a borrow occurs. AC is set to the carry out of bit 3 of the sum acc + ~operand + (1 − borrow_in).
- R5: Compare (op 7) sets every flag exactly as op 2 would for the same inputs and leaves the accumulator unchanged.
- R6: AND (op 4), XOR (op 5) and OR (op 6) write the bitwise result to the accumulator and clear C and AC.
- R7: For ops 0–7 and 12, Z is 1 exactly when the 8-bit result is zero, S equals result bit 7, and P is 1 when the result holds an even number of ones. For op 7 the result is the difference, which is not stored.
- R8: The rotates change only C. Op 8 rotates left with bit 7 going both to bit 0 and to C. Op 9 rotates right with bit 0 going both to bit 7 and to C. Op 10 rotates left through C (old C goes to bit 0, bit 7 goes to C). Op 11 rotates right through C (old C goes to bit 7, bit 0 goes to C).
- R9: Decimal adjust (op 12) adds 0x06 when the low digit is above 9 or AC is 1. It adds 0x60 when the accumulator is above 0x99 or C is 1, and in that case it sets C; otherwise C is kept. AC becomes the carry out of bit 3 of that addition.
- R10: Load (op 13) copies the operand into the accumulator and leaves the flags unchanged.
- R11: The flag byte holds S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and C at bit 0. Bits 5, 3 and 1 always read 0. The status word is {accumulator, flag byte}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe | input | 1 | Commits the selected operation on this clock edge |
| op | input | 4 | Operation code |
| operand | input | 8 | Second operand from a register or immediate byte |
| acc_q | output | 8 | Accumulator |
| flags_q | output | 8 | Flag byte |
| status_q | output | 16 | Accumulator in the upper byte, flags in the lower byte |

## Verification
The properties assume that strobe stays low while the internal reset is still held after rst_n rises. They also assume that op and operand are stable across the clock edge at which strobe is sampled. The bench drives every input on the falling edge and keeps strobe high for exactly one cycle per operation. It starts its first operation only after several cycles of released reset. The bench also drives undefined op codes and toggles op and operand with strobe low, so that the hold rule is exercised through the ports.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADC  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SBB  = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_XOR  = 4'd5;
  localparam logic [3:0] OP_OR   = 4'd6;
  localparam logic [3:0] OP_CMP  = 4'd7;
  localparam logic [3:0] OP_RLC  = 4'd8;
  localparam logic [3:0] OP_RRC  = 4'd9;
  localparam logic [3:0] OP_RAL  = 4'd10;
  localparam logic [3:0] OP_RAR  = 4'd11;
  localparam logic [3:0] OP_DAA  = 4'd12;
  localparam logic [3:0] OP_LOAD = 4'd13;

  localparam int FLG_C  = 0;
  localparam int FLG_P  = 2;
  localparam int FLG_AC = 4;
  localparam int FLG_Z  = 6;
  localparam int FLG_S  = 7;

  typedef struct packed {
    logic s;
    logic z;
    logic rsv5;
    logic ac;
    logic rsv3;
    logic p;
    logic rsv1;
    logic c;
  } flags_t;

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cf,
  input  logic         sub,
  input  logic         use_c,
  output logic [W-1:0] res,
  output logic         cy,
  output logic         ac
);

  logic [W-1:0] b_eff;
  logic         c0;
  logic [W:0]   full;
  logic [4:0]   low;

  always_comb begin
    b_eff = sub ? ~b : b;
    c0    = sub ? ~(use_c & cf) : (use_c & cf);
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
    low   = {1'b0, a[3:0]} + {1'b0, b_eff[3:0]} + {4'b0000, c0};
    res   = full[W-1:0];
    cy    = sub ? ~full[W] : full[W];
    ac    = low[4];
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cf,
  input  logic [3:0]   op,
  output logic [W-1:0] res,
  output logic         cy
);

  always_comb begin
    res = a;
    cy  = cf;
    unique case (op)
      OP_AND: res = a & b;
      OP_XOR: res = a ^ b;
      OP_OR:  res = a | b;
      OP_RLC: begin res = {a[W-2:0], a[W-1]}; cy = a[W-1]; end
      OP_RRC: begin res = {a[0], a[W-1:1]};   cy = a[0];   end
      OP_RAL: begin res = {a[W-2:0], cf};     cy = a[W-1]; end
      OP_RAR: begin res = {cf, a[W-1:1]};     cy = a[0];   end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         ac_in,
  input  logic         cy_in,
  output logic [W-1:0] res,
  output logic         ac_out,
  output logic         cy_out
);

  localparam int NIB = W / 4;

  logic [NIB-1:0] fix;
  logic [W-1:0]   corr;
  logic [4:0]     low;

  for (genvar i = 0; i < NIB; i++) begin : g_nib
    localparam int HI = 4*i + 3;
    localparam logic [HI:0] MAX9 = {(i+1){4'h9}};
    logic flag_in;
    if (i == 0) begin : g_lo
      assign flag_in = ac_in;
    end else if (i == NIB-1) begin : g_hi
      assign flag_in = cy_in;
    end else begin : g_mid
      assign flag_in = 1'b0;
    end
    assign fix[i]        = (a[HI:0] > MAX9) || flag_in;
    assign corr[HI -: 4] = fix[i] ? 4'h6 : 4'h0;
  end

  always_comb begin
    res    = a + corr;
    low    = {1'b0, a[3:0]} + {1'b0, corr[3:0]};
    ac_out = low[4];
    cy_out = cy_in | fix[NIB-1];
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [3:0]    op,
  input  logic [W-1:0]  operand,
  output logic [W-1:0]  acc_q,
  output logic [7:0]    flags_q,
  output logic [W+7:0]  status_q
);

  logic [1:0]   rst_sync;
  logic         rst_sync_n;
  logic [W-1:0] acc_r, acc_nx;
  flags_t       flg_r, flg_nx;

  logic         is_sub, use_c;
  logic [W-1:0] ar_res, lg_res, da_res;
  logic         ar_cy, ar_ac, lg_cy, da_cy, da_ac;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  assign is_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  assign use_c  = (op == OP_ADC) || (op == OP_SBB);

  acc_alu_arith #(.W(W)) i_arith (
    .a(acc_r), .b(operand), .cf(flg_r.c), .sub(is_sub), .use_c(use_c),
    .res(ar_res), .cy(ar_cy), .ac(ar_ac)
  );

  acc_alu_logic #(.W(W)) i_logic (
    .a(acc_r), .b(operand), .cf(flg_r.c), .op(op),
    .res(lg_res), .cy(lg_cy)
  );

  acc_alu_decadj #(.W(W)) i_decadj (
    .a(acc_r), .ac_in(flg_r.ac), .cy_in(flg_r.c),
    .res(da_res), .ac_out(da_ac), .cy_out(da_cy)
  );

  function automatic flags_t zsp(input flags_t f, input logic [W-1:0] r);
    flags_t o;
    o   = f;
    o.z = (r == '0);
    o.s = r[W-1];
    o.p = ~^r;
    return o;
  endfunction

  // next-state selection
  always_comb begin
    acc_nx = acc_r;
    flg_nx = flg_r;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        acc_nx    = ar_res;
        flg_nx    = zsp(flg_r, ar_res);
        flg_nx.c  = ar_cy;
        flg_nx.ac = ar_ac;
      end
      OP_CMP: begin
        flg_nx    = zsp(flg_r, ar_res);
        flg_nx.c  = ar_cy;
        flg_nx.ac = ar_ac;
      end
      OP_AND, OP_XOR, OP_OR: begin
        acc_nx    = lg_res;
        flg_nx    = zsp(flg_r, lg_res);
        flg_nx.c  = 1'b0;
        flg_nx.ac = 1'b0;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        acc_nx   = lg_res;
        flg_nx.c = lg_cy;
      end
      OP_DAA: begin
        acc_nx    = da_res;
        flg_nx    = zsp(flg_r, da_res);
        flg_nx.c  = da_cy;
        flg_nx.ac = da_ac;
      end
      OP_LOAD: acc_nx = operand;
      default: ;
    endcase
    flg_nx.rsv5 = 1'b0;
    flg_nx.rsv3 = 1'b0;
    flg_nx.rsv1 = 1'b0;
  end

  // state registers with explicit enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_r <= '0;
      flg_r <= '0;
    end else if (strobe) begin
      acc_r <= acc_nx;
      flg_r <= flg_nx;
    end
  end

  assign acc_q    = acc_r;
  assign flags_q  = flg_r;
  assign status_q = {acc_r, flg_r};

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         strobe,
  input logic [3:0]   op,
  input logic [W-1:0] operand,
  input logic [W-1:0] acc_q,
  input logic [7:0]   flags_q
);

  logic res_op, logic_op, rot_op;
  assign res_op   = op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_AND, OP_XOR, OP_OR, OP_DAA};
  assign logic_op = op inside {OP_AND, OP_XOR, OP_OR};
  assign rot_op   = op inside {OP_RLC, OP_RRC, OP_RAL, OP_RAR};

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(acc_q) && $stable(flags_q))); // R2

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && op == OP_ADD) |=> acc_q == W'($past(acc_q) + $past(operand))); // R3

  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && op == OP_CMP) |=> $stable(acc_q)); // R5

  AST_LOGIC_CLEARS_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && logic_op) |=> (!flags_q[FLG_C] && !flags_q[FLG_AC])); // R6

  AST_RESULT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && res_op) |=> (flags_q[FLG_Z] == (acc_q == '0)) &&
                           (flags_q[FLG_S] == acc_q[W-1]) &&
                           (flags_q[FLG_P] == ~^acc_q)); // R7

  AST_ROT_ONLY_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && rot_op) |=> flags_q[7:1] == $past(flags_q[7:1])); // R8

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && op == OP_LOAD) |=> (acc_q == $past(operand)) && $stable(flags_q)); // R10

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[5] == 1'b0) && (flags_q[3] == 1'b0) && (flags_q[1] == 1'b0)); // R11

endmodule

bind acc_alu acc_alu_chk #(.W(W)) i_acc_alu_chk (
  .clk(clk), .rst_n(rst_sync_n), .strobe(strobe), .op(op),
  .operand(operand), .acc_q(acc_q), .flags_q(flags_q)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;
  import alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [7:0]  operand = 8'd0;
  logic [7:0]  acc_q, flags_q;
  logic [15:0] status_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_acc = 8'd0;
  logic [7:0] m_f   = 8'd0;

  always #5 clk = ~clk;

  acc_alu i_acc_alu (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .op(op),
    .operand(operand), .acc_q(acc_q), .flags_q(flags_q), .status_q(status_q)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_flags(input logic [7:0] r, input logic c, input logic ac);
    return {r[7], (r == 8'h00), 1'b0, ac, 1'b0, ~^r, 1'b0, c};
  endfunction

  // reference behaviour written from the requirements
  task automatic model_step(input logic [3:0] o, input logic [7:0] b);
    int ia, ib, t, lo, corr;
    logic c, ac;
    logic [7:0] r;
    ia = int'(m_acc); ib = int'(b);
    c = m_f[0]; ac = m_f[4];
    case (o)
      OP_ADD, OP_ADC: begin
        t  = ia + ib + ((o == OP_ADC) ? int'(c) : 0);
        lo = (ia % 16) + (ib % 16) + ((o == OP_ADC) ? int'(c) : 0);
        r  = t[7:0];
        m_f = mk_flags(r, t > 255, lo > 15); m_acc = r;
      end
      OP_SUB, OP_SBB, OP_CMP: begin
        t  = ia + (255 - ib) + 1 - ((o == OP_SBB) ? int'(c) : 0);
        lo = (ia % 16) + (15 - (ib % 16)) + 1 - ((o == OP_SBB) ? int'(c) : 0);
        r  = t[7:0];
        m_f = mk_flags(r, !(t > 255), lo > 15);
        if (o != OP_CMP) m_acc = r;
      end
      OP_AND: begin r = m_acc & b; m_f = mk_flags(r, 1'b0, 1'b0); m_acc = r; end
      OP_XOR: begin r = m_acc ^ b; m_f = mk_flags(r, 1'b0, 1'b0); m_acc = r; end
      OP_OR:  begin r = m_acc | b; m_f = mk_flags(r, 1'b0, 1'b0); m_acc = r; end
      OP_RLC: begin m_f[0] = m_acc[7]; m_acc = {m_acc[6:0], m_acc[7]}; end
      OP_RRC: begin m_f[0] = m_acc[0]; m_acc = {m_acc[0], m_acc[7:1]}; end
      OP_RAL: begin m_f[0] = m_acc[7]; m_acc = {m_acc[6:0], c}; end
      OP_RAR: begin m_f[0] = m_acc[0]; m_acc = {c, m_acc[7:1]}; end
      OP_DAA: begin
        corr = 0;
        if ((ia % 16) > 9 || ac) corr += 6;
        if (ia > 153 || c) begin corr += 96; c = 1'b1; end
        lo = (ia % 16) + (corr % 16);
        t  = ia + corr;
        r  = t[7:0];
        m_f = mk_flags(r, c, lo > 15); m_acc = r;
      end
      OP_LOAD: m_acc = b;
      default: ;
    endcase
  endtask

  task automatic do_op(input string tag, input logic [3:0] o, input logic [7:0] b);
    model_step(o, b);
    @(negedge clk);
    op = o; operand = b; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    chk(tag, {acc_q, flags_q}, {m_acc, m_f});
  endtask

  task automatic t_reset();
    chk("R1 reset acc/flags", {acc_q, flags_q}, 16'h0000);
    chk("R11 reset status", status_q, 16'h0000);
  endtask

  task automatic t_add();
    do_op("R10 load", OP_LOAD, 8'h3A);
    do_op("R3 add to zero", OP_ADD, 8'hC6);
    chk("R7 flags after wrap", {8'h00, flags_q}, 16'h0055);
    do_op("R3 adc with carry", OP_ADC, 8'h01);
    chk("R3 adc value", {8'h00, acc_q}, 16'h0002);
    for (int i = 0; i < 12; i++) begin
      do_op("R3 add sweep", (i % 2 == 0) ? OP_ADD : OP_ADC, 8'(i * 37 + 11));
    end
  endtask

  task automatic t_sub();
    do_op("R10 load", OP_LOAD, 8'h10);
    do_op("R4 sub borrow", OP_SUB, 8'h20);
    chk("R4 borrow result", {acc_q, 7'd0, flags_q[0]}, 16'hF001);
    do_op("R4 sbb with borrow", OP_SBB, 8'h0F);
    chk("R4 sbb value", {8'h00, acc_q}, 16'h00E0);
    for (int i = 0; i < 12; i++) begin
      do_op("R4 sub sweep", (i % 2 == 0) ? OP_SUB : OP_SBB, 8'(i * 53 + 7));
    end
  endtask

  task automatic t_cmp();
    do_op("R10 load", OP_LOAD, 8'h42);
    do_op("R5 cmp equal", OP_CMP, 8'h42);
    chk("R5 cmp equal Z, acc kept", {acc_q, 7'd0, flags_q[6]}, 16'h4201);
    do_op("R5 cmp below", OP_CMP, 8'h50);
    chk("R7 cmp sign of diff", {acc_q, flags_q[7], 6'd0, flags_q[0]}, 16'h4281);
  endtask

  task automatic t_logic();
    do_op("R10 load", OP_LOAD, 8'hFF);
    do_op("R3 set carry", OP_ADD, 8'hFF);
    do_op("R6 and", OP_AND, 8'h0F);
    chk("R6 and clears C", {acc_q, 7'd0, flags_q[0]}, 16'h0E00);
    do_op("R6 xor", OP_XOR, 8'h0E);
    chk("R7 xor zero flag", {acc_q, flags_q}, 16'h0044);
    do_op("R6 or", OP_OR, 8'hA1);
    do_op("R6 xor odd", OP_XOR, 8'h10);
  endtask

  task automatic t_rotate();
    do_op("R10 load", OP_LOAD, 8'h81);
    do_op("R8 rlc", OP_RLC, 8'h00);
    chk("R8 rlc value", {acc_q, 7'd0, flags_q[0]}, 16'h0301);
    do_op("R8 rrc", OP_RRC, 8'h00);
    do_op("R8 rrc again", OP_RRC, 8'h00);
    do_op("R8 ral", OP_RAL, 8'h00);
    do_op("R8 ral again", OP_RAL, 8'h00);
    do_op("R8 rar", OP_RAR, 8'h00);
    do_op("R8 rar again", OP_RAR, 8'h00);
  endtask

  task automatic t_daa();
    do_op("R10 load", OP_LOAD, 8'h15);
    do_op("R3 bcd add", OP_ADD, 8'h27);
    do_op("R9 daa low fix", OP_DAA, 8'h00);
    chk("R9 15+27=42", {8'h00, acc_q}, 16'h0042);
    do_op("R10 load", OP_LOAD, 8'h99);
    do_op("R3 bcd add", OP_ADD, 8'h01);
    do_op("R9 daa both fix", OP_DAA, 8'h00);
    chk("R9 99+01=00 carry", {acc_q, 7'd0, flags_q[0]}, 16'h0001);
    do_op("R10 load", OP_LOAD, 8'h09);
    do_op("R3 bcd add", OP_ADD, 8'h09);
    do_op("R9 daa via AC", OP_DAA, 8'h00);
    chk("R9 09+09=18", {8'h00, acc_q}, 16'h0018);
    do_op("R10 load", OP_LOAD, 8'h50);
    do_op("R3 bcd add", OP_ADD, 8'h70);
    do_op("R9 daa high only", OP_DAA, 8'h00);
    chk("R9 50+70=20 carry", {acc_q, 7'd0, flags_q[0]}, 16'h2001);
  endtask

  task automatic t_hold();
    logic [15:0] snap;
    do_op("R10 load", OP_LOAD, 8'h5C);
    do_op("R3 make flags", OP_ADD, 8'hB7);
    snap = status_q;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op = 4'(i); operand = 8'(i * 61);
    end
    @(negedge clk);
    chk("R2 idle hold", status_q, snap);
    do_op("R2 undefined op 14", 4'd14, 8'h33);
    do_op("R2 undefined op 15", 4'd15, 8'hCC);
    chk("R2 undefined keeps state", status_q, snap);
    do_op("R10 load keeps flags", OP_LOAD, 8'h00);
    chk("R11 status word", status_q, {acc_q, flags_q});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_rotate();
    t_daa();
    t_hold();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule